// File: doc/BRIEF.md
# DRAM Idle Low-Power State Sequencer

This block watches a single bus-activity indication and counts how many DFI clock cycles in a row the memory bus has stayed quiet. The DFI clock runs at half the DRAM clock. As the count passes a set of programmable thresholds, the block asks for deeper and deeper low-power states. The order of depth is: power-down, self-refresh, self-refresh with controller clock gating, a lite self-refresh power-down that only LPDDR4 devices get, and finally full standby, where every clock is gated. Any sign of bus activity wakes the sequencer at once.

The power-down and standby thresholds are compared against the raw idle-cycle count. The three self-refresh thresholds are given in units of 1024 DFI cycles. They are compared against a coarse count that a 1024-cycle prescaler advances. Both counts share one idle run and clear together.

The block only requests states and drives clock-gate enables. A downstream controller carries out the actual DRAM commands, the exit timing and the PHY handling. All pins are plain control and status pins, with no stream handshake.

Top module: `dram_idle_lp_seq`

## Requirements
- R1: After reset, `lvl_onehot` is 6'b000001 (ACTIVE) and all three gate enables are 0. The one-hot bit positions are: bit0 ACTIVE, bit1 PD, bit2 SR, bit3 SR_GATE, bit4 SRPD_LITE, bit5 STANDBY. Exactly one bit is set at all times.
- R2: Power-down (bit1) is requested once the idle run reaches `thr_pd` cycles, counted unscaled. Because of the output register, it appears after idle clock edge `thr_pd`+1 and not earlier.
- R3: Self-refresh (bit2) is requested once the idle run reaches `thr_sr`×1024 cycles. It appears after idle edge `thr_sr`×1024+1.
- R4: Self-refresh with controller clock gating (bit3) is requested at `thr_sr_gate`×1024 idle cycles. `gate_ctrl_clk` is 1 only in SR_GATE or STANDBY.
- R5: SRPD_LITE (bit4) is requested at `thr_srpd`×1024 idle cycles, but only when `dram_is_lp4` is 1. Otherwise that threshold has no effect on the state.
- R6: Bus activity clears the idle count and the 1024-cycle prescaler together. A partial 1024-cycle block from before the activity does not count afterwards.
- R7: On a cycle with `bus_busy`=1, all gate enables are 0 after that edge while the state output keeps its old value. After the following edge the state is ACTIVE.
- R8: A threshold value of 0 disables its state, and that state is skipped. When several thresholds are reached, the deepest enabled one is requested.
- R9: STANDBY (bit5) is requested at `thr_standby` idle cycles, counted unscaled. In STANDBY, `gate_ctrl_clk`, `gate_phy_clk` and `gate_dram_clk` are all 1.
- R10: While the bus stays idle, the coarse 1024-cycle count advances by at most one per cycle and saturates rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DFI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_busy | input | 1 | 1 when the memory bus has activity this cycle |
| dram_is_lp4 | input | 1 | 1 when the attached DRAM is LPDDR4 |
| thr_pd | input | PD_W | Power-down threshold in idle cycles, 0 disables |
| thr_sr | input | SC_W | Self-refresh threshold in 1024-cycle units, 0 disables |
| thr_sr_gate | input | SC_W | Gated self-refresh threshold in 1024-cycle units, 0 disables |
| thr_srpd | input | SC_W | LPDDR4 lite self-refresh power-down threshold in 1024-cycle units, 0 disables |
| thr_standby | input | SB_W | Standby threshold in idle cycles, 0 disables |
| lvl_onehot | output | 6 | Requested state, one-hot |
| gate_ctrl_clk | output | 1 | Controller clock gate enable |
| gate_phy_clk | output | 1 | PHY-interface clock gate enable |
| gate_dram_clk | output | 1 | DRAM clock gate enable |

## Verification
The bench probes each threshold one cycle before and one cycle after its boundary. An off-by-one in the count or in the ×1024 scaling shows up as a state that arrives a cycle early or late. A wake pulse in the middle of a prescaler block checks that the partial block is thrown away; a prescaler that survives the activity would grant self-refresh about 600 cycles early. The LPDDR4 gating, the skipping of disabled tiers and the release order on wake are each driven directly: a design that lets the state drop together with the gates, or that grants SRPD_LITE to a non-LPDDR4 part, shows the wrong output on the sampled cycle.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  typedef enum logic [2:0] {
    LP_ACTIVE  = 3'd0,
    LP_PD      = 3'd1,
    LP_SR      = 3'd2,
    LP_SRGATE  = 3'd3,
    LP_SRPD    = 3'd4,
    LP_STANDBY = 3'd5
  } lp_level_e;

  localparam int LP_NUM = 6;
  // number of tiers whose threshold is expressed in 1024-cycle units
  localparam int LP_SCALED = 3;
endpackage

// File: rtl/lp_idle_counter.sv
module lp_idle_counter #(
  parameter int RAW_W    = 16,
  parameter int KILO_W   = 8,
  parameter int DIV_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_busy,
  output logic [RAW_W-1:0]  raw_cnt,
  output logic [KILO_W-1:0] kilo_cnt
);
  localparam logic [DIV_LOG2-1:0] PRE_LAST = {DIV_LOG2{1'b1}};
  localparam logic [RAW_W-1:0]    RAW_MAX  = {RAW_W{1'b1}};
  localparam logic [KILO_W-1:0]   KILO_MAX = {KILO_W{1'b1}};

  logic [DIV_LOG2-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n || bus_busy) begin
      raw_cnt  <= '0;
      kilo_cnt <= '0;
      pre_q    <= '0;
    end else begin
      if (raw_cnt != RAW_MAX) raw_cnt <= raw_cnt + 1'b1;
      pre_q <= pre_q + 1'b1;
      if (pre_q == PRE_LAST && kilo_cnt != KILO_MAX) kilo_cnt <= kilo_cnt + 1'b1;
    end
  end

  // R6: activity empties both counts on the next edge
  a_r6_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> (raw_cnt == '0 && kilo_cnt == '0));

  // R10: coarse count moves by at most one step and never wraps
  a_r10_kilo_step: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |=> (kilo_cnt == $past(kilo_cnt) || kilo_cnt == $past(kilo_cnt) + 1'b1));
endmodule

// File: rtl/lp_level_select.sv
module lp_level_select
  import lp_seq_pkg::*;
#(
  parameter int RAW_W  = 16,
  parameter int KILO_W = 8,
  parameter int PD_W   = 8,
  parameter int SB_W   = 16
) (
  input  logic [RAW_W-1:0]                 raw_cnt,
  input  logic [KILO_W-1:0]                kilo_cnt,
  input  logic                             dram_is_lp4,
  input  logic [PD_W-1:0]                  thr_pd,
  input  logic [LP_SCALED-1:0][KILO_W-1:0] thr_scaled,
  input  logic [SB_W-1:0]                  thr_standby,
  output lp_level_e                        target
);
  logic [LP_NUM-1:0] hit;
  logic [RAW_W-1:0]  pd_ext, sb_ext;

  assign pd_ext = RAW_W'(thr_pd);
  assign sb_ext = RAW_W'(thr_standby);

  assign hit[0] = 1'b1;
  assign hit[1] = (thr_pd != '0) && (raw_cnt >= pd_ext);

  for (genvar g = 0; g < LP_SCALED; g++) begin : g_scaled
    logic reached;
    assign reached = (thr_scaled[g] != '0) && (kilo_cnt >= thr_scaled[g]);
    if (g + 2 == int'(LP_SRPD)) begin : g_lp4_only
      assign hit[g+2] = reached && dram_is_lp4;
    end else begin : g_any_type
      assign hit[g+2] = reached;
    end
  end

  assign hit[5] = (thr_standby != '0) && (raw_cnt >= sb_ext);

  // deepest reached tier wins
  always_comb begin
    target = LP_ACTIVE;
    for (int i = 1; i < LP_NUM; i++) begin
      if (hit[i]) target = lp_level_e'(3'(i));
    end
  end
endmodule

// File: rtl/dram_idle_lp_seq.sv
module dram_idle_lp_seq
  import lp_seq_pkg::*;
#(
  parameter int PD_W     = 8,
  parameter int SC_W     = 8,
  parameter int SB_W     = 16,
  parameter int RAW_W    = 16,
  parameter int DIV_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_busy,
  input  logic             dram_is_lp4,
  input  logic [PD_W-1:0]  thr_pd,
  input  logic [SC_W-1:0]  thr_sr,
  input  logic [SC_W-1:0]  thr_sr_gate,
  input  logic [SC_W-1:0]  thr_srpd,
  input  logic [SB_W-1:0]  thr_standby,
  output logic [5:0]       lvl_onehot,
  output logic             gate_ctrl_clk,
  output logic             gate_phy_clk,
  output logic             gate_dram_clk
);
  logic [RAW_W-1:0]              raw_cnt;
  logic [SC_W-1:0]               kilo_cnt;
  logic [LP_SCALED-1:0][SC_W-1:0] thr_scaled;
  lp_level_e                     target, level_q;
  logic                          wake_q;

  assign thr_scaled = {thr_srpd, thr_sr_gate, thr_sr};

  lp_idle_counter #(.RAW_W(RAW_W), .KILO_W(SC_W), .DIV_LOG2(DIV_LOG2)) u_cnt (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy),
    .raw_cnt(raw_cnt), .kilo_cnt(kilo_cnt)
  );

  lp_level_select #(.RAW_W(RAW_W), .KILO_W(SC_W), .PD_W(PD_W), .SB_W(SB_W)) u_sel (
    .raw_cnt(raw_cnt), .kilo_cnt(kilo_cnt), .dram_is_lp4(dram_is_lp4),
    .thr_pd(thr_pd), .thr_scaled(thr_scaled), .thr_standby(thr_standby),
    .target(target)
  );

  // gates drop on the busy edge; the state follows one edge later
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q       <= LP_ACTIVE;
      wake_q        <= 1'b0;
      gate_ctrl_clk <= 1'b0;
      gate_phy_clk  <= 1'b0;
      gate_dram_clk <= 1'b0;
    end else begin
      wake_q <= bus_busy;
      if (wake_q)         level_q <= LP_ACTIVE;
      else if (!bus_busy) level_q <= target;
      if (bus_busy || wake_q) begin
        gate_ctrl_clk <= 1'b0;
        gate_phy_clk  <= 1'b0;
        gate_dram_clk <= 1'b0;
      end else begin
        gate_ctrl_clk <= (target == LP_SRGATE) || (target == LP_STANDBY);
        gate_phy_clk  <= (target == LP_STANDBY);
        gate_dram_clk <= (target == LP_STANDBY);
      end
    end
  end

  assign lvl_onehot = 6'(1) << level_q;

  // R1: state output is always one-hot
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(lvl_onehot));

  // R7: gates released on the busy edge, state active one edge later
  a_r7_gates_release: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> (!gate_ctrl_clk && !gate_phy_clk && !gate_dram_clk));
  a_r7_active_after: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> ##1 (lvl_onehot == 6'b000001));

  // R4: controller gate only in a gated state
  a_r4_ctrl_gate_state: assert property (@(posedge clk) disable iff (!rst_n)
    gate_ctrl_clk |-> (lvl_onehot[3] || lvl_onehot[5]));

  // R9: dram and phy gates only in standby
  a_r9_full_gate_state: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_dram_clk || gate_phy_clk) |-> lvl_onehot[5]);

  // R5: lite state entered only with an LPDDR4 part
  a_r5_lp4_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_onehot[4]) |-> $past(dram_is_lp4));
endmodule

// File: tb/dram_idle_lp_seq_tb_top.sv
module dram_idle_lp_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_busy = 1'b1;
  logic        dram_is_lp4 = 1'b0;
  logic [7:0]  thr_pd = '0, thr_sr = '0, thr_sr_gate = '0, thr_srpd = '0;
  logic [15:0] thr_standby = '0;
  logic [5:0]  lvl_onehot;
  logic        gate_ctrl_clk, gate_phy_clk, gate_dram_clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [5:0] lvl;
    logic [2:0] gates;  // {ctrl, phy, dram}
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  dram_idle_lp_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .dram_is_lp4(dram_is_lp4),
    .thr_pd(thr_pd), .thr_sr(thr_sr), .thr_sr_gate(thr_sr_gate),
    .thr_srpd(thr_srpd), .thr_standby(thr_standby),
    .lvl_onehot(lvl_onehot), .gate_ctrl_clk(gate_ctrl_clk),
    .gate_phy_clk(gate_phy_clk), .gate_dram_clk(gate_dram_clk)
  );

  localparam logic [5:0] S_ACT = 6'b000001, S_PD = 6'b000010, S_SR = 6'b000100,
                         S_SRG = 6'b001000, S_SRPD = 6'b010000, S_SB = 6'b100000;

  // monitor: pop one expected item and compare at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      logic [2:0] g;
      e = exp_q.pop_front();
      g = {gate_ctrl_clk, gate_phy_clk, gate_dram_clk};
      n_checks++;
      if (lvl_onehot !== e.lvl || g !== e.gates) begin
        n_fail++;
        $display("FAIL %s: lvl=%b gates=%b expected lvl=%b gates=%b",
                 e.tag, lvl_onehot, g, e.lvl, e.gates);
      end
    end
  end

  task automatic run_idle(input int n);
    bus_busy = 1'b0;
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic run_busy(input int n);
    bus_busy = 1'b1;
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic expect_now(input logic [5:0] lvl, input logic [2:0] gates, input string tag);
    exp_t e;
    e.lvl = lvl; e.gates = gates; e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expect_now(S_ACT, 3'b000, "R1 reset state");
    rst_n = 1'b1;
    thr_pd = 8'd5; thr_sr = 8'd1; thr_sr_gate = 8'd2; thr_srpd = 8'd3; thr_standby = '0;
    dram_is_lp4 = 1'b0;
    run_busy(2);

    run_idle(5);    expect_now(S_ACT, 3'b000, "R2 before pd");
    run_idle(1);    expect_now(S_PD,  3'b000, "R2 pd at threshold");
    run_idle(1018); expect_now(S_PD,  3'b000, "R3 before sr");
    run_idle(1);    expect_now(S_SR,  3'b000, "R3 sr at 1024");
    run_idle(1023); expect_now(S_SR,  3'b000, "R4 before sr_gate");
    run_idle(1);    expect_now(S_SRG, 3'b100, "R4 sr_gate with ctrl gate");
    run_idle(1024); expect_now(S_SRG, 3'b100, "R5 lite ignored without lp4");

    run_busy(1);    expect_now(S_SRG, 3'b000, "R7 gates drop first");
    run_idle(1);    expect_now(S_ACT, 3'b000, "R7 active next edge");
    run_idle(4);    expect_now(S_ACT, 3'b000, "R6 count cleared");
    run_idle(1);    expect_now(S_PD,  3'b000, "R6 pd recounted");

    run_idle(594);
    run_busy(1);
    run_idle(1024); expect_now(S_PD,  3'b000, "R6 prescaler cleared");
    run_idle(1);    expect_now(S_SR,  3'b000, "R6 sr after full block");

    // LPDDR4 profile, pd disabled
    run_busy(2);
    dram_is_lp4 = 1'b1;
    thr_pd = '0; thr_sr = 8'd1; thr_sr_gate = '0; thr_srpd = 8'd2; thr_standby = 16'd4000;
    run_busy(1);
    run_idle(6);    expect_now(S_ACT, 3'b000, "R8 pd disabled");
    run_idle(1019); expect_now(S_SR,  3'b000, "R8 sr reached");
    run_idle(1024); expect_now(S_SRPD,3'b000, "R5 lite with lp4");
    run_idle(1951); expect_now(S_SRPD,3'b000, "R9 before standby");
    run_idle(1);    expect_now(S_SB,  3'b111, "R9 standby all gates");
    run_busy(1);    expect_now(S_SB,  3'b000, "R7 standby gates drop");
    run_busy(1);    expect_now(S_ACT, 3'b000, "R7 active under busy");

    // skip disabled middle tiers
    dram_is_lp4 = 1'b0;
    thr_pd = 8'd3; thr_sr = '0; thr_sr_gate = '0; thr_srpd = '0; thr_standby = 16'd10;
    run_busy(1);
    run_idle(4);    expect_now(S_PD,  3'b000, "R8 pd first");
    run_idle(7);    expect_now(S_SB,  3'b111, "R8 deepest standby");
    run_idle(2000); expect_now(S_SB,  3'b111, "R10 holds with long idle");

    run_idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule